// File: doc/BRIEF.md
# Tiled Address Bit-Field Merge

This block takes three packed per-axis words, one each for x, y and z, and folds them into a single 32-bit address bit-field plus an out-of-bounds predicate. Each word comes from an earlier coordinate-clamp stage. The low byte of the result is a byte offset inside one tile. The upper fields carry a shift amount and a tile-level offset that a later address-add stage consumes. The block has two layouts. The tiled (block-linear) layout swizzles in-tile coordinate bits into a fixed non-linear order and packs the z|y|x tile coordinates at variable positions. The pitch-linear 2D layout scales a byte coordinate by the element size.

Whether z takes part is fixed per instance by the parameter `IS_3D`. A single register stage sits between the inputs and the outputs. `out_valid` follows `in_valid` one cycle later, and the outputs hold their value while no new input is accepted.

Top module: `tile_bf_merge`

## Requirements
- R1: The pitch-linear 2D layout is selected when bit 30 of `x_word` or bit 30 of `y_word` is set. Otherwise the tiled layout is used. Output bit 11 is 1 exactly in the pitch-linear case.
- R2: In the tiled layout the in-tile bits are: out[3:0]=x[19:16], out[4]=y[16], out[5]=y[17], out[6]=x[20], out[7]=y[18], out[8]=x[21].
- R3: In the tiled layout, out[15:12] = tx + ty + tz. Here tx=x[27] (one bit), ty=y[29:27] and tz=z[29:27].
- R4: In the tiled layout, out[26:16] = ((c·2^ty + b)·2^tx + a), reduced modulo 1024 when tx=0 and modulo 2048 when tx=1. The terms are a = x[22] when tx=1 and 0 otherwise, b = y[23:19] mod 2^min(ty,5), and c = z[23:16] mod 2^min(tz,5).
- R5: With `IS_3D`=0, tz is taken as 0 and z[31] has no effect on `out_oob`.
- R6: In the pitch-linear layout, out[7:0] = (z[7:0]·2^e) mod 256 and out[14:12] = e, where e = x[29:27].
- R7: Bits 10:9 are always 0. In the tiled layout bits 31:27 are 0. In the pitch-linear layout every bit not named in R1 or R6 is 0.
- R8: `out_oob` = x[31] OR y[31] OR (z[31] AND `IS_3D`), in both layouts.
- R9: `out_valid` equals `in_valid` of the previous cycle. Results appear one clock after `in_valid` is sampled high. `out_field` and `out_oob` keep their value when `in_valid` is low.
- R10: While `rst_n` is low, `out_valid`, `out_field` and `out_oob` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input words are valid this cycle |
| x_word | input | 32 | Packed x-axis word |
| y_word | input | 32 | Packed y-axis word |
| z_word | input | 32 | Packed z-axis word |
| out_valid | output | 1 | Registered result is valid |
| out_field | output | 32 | Merged address bit-field |
| out_oob | output | 1 | Out-of-bounds predicate |

## Verification
The bench sweeps every combination of tx, ty and tz with random coordinate bits, on a 3D instance and a 2D instance side by side.

- ty and tz of 6 and 7 check the 5-bit cap on b and c. A design that skipped the cap would leak extra coordinate bits into the tile offset.
- tx=0 against tx=1 checks the 10-bit and 11-bit masks. A wrong mask keeps or drops bit 26.
- The 2D instance shows whether tz or z[31] leaks in when z is excluded.
- The pitch-linear sweep covers every element size with boundary byte values, to expose a shift that is not truncated to 8 bits.
- Every combination of the three top bits is tried for the out-of-bounds predicate.
- A hold phase confirms that a result does not change when `in_valid` is low.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
   localparam int WORD_W     = 32;
   localparam int OOB_BIT    = 31;
   localparam int PL_BIT     = 30;
   localparam int NT_LSB     = 27;
   localparam int NT_W       = 3;
   localparam int SUM_W      = 4;
   localparam int TILE_W     = 11;
   localparam int INTILE_W   = 9;
   localparam int SUM_LSB    = 12;
   localparam int TILE_LSB   = 16;
   localparam int PLFLAG_BIT = 11;
   localparam int CALC_W     = 16;
endpackage

// File: rtl/tbm_swizzle.sv
module tbm_swizzle
   import tbm_pkg::*;
(
   input  logic [WORD_W-1:0]   x_w,
   input  logic [WORD_W-1:0]   y_w,
   output logic [INTILE_W-1:0] intile
);
   always_comb begin
      intile[3:0] = x_w[19:16];
      intile[4]   = y_w[16];
      intile[5]   = y_w[17];
      intile[6]   = x_w[20];
      intile[7]   = y_w[18];
      intile[8]   = x_w[21];
   end
endmodule

// File: rtl/tbm_tile_compose.sv
module tbm_tile_compose
   import tbm_pkg::*;
#(
   parameter bit IS_3D    = 1'b1,
   parameter int TILE_CAP = 5
) (
   input  logic [WORD_W-1:0] x_w,
   input  logic [WORD_W-1:0] y_w,
   input  logic [WORD_W-1:0] z_w,
   output logic [SUM_W-1:0]  shift_sum,
   output logic [TILE_W-1:0] tile_off
);
   localparam logic [NT_W-1:0] CAP_V = NT_W'(TILE_CAP);

   logic [NT_W-1:0]   ntx, nty, ntz, bw, cw;
   logic [CALC_W-1:0] a_v, b_v, c_v, mask_b, mask_c, comp;

   generate
      if (IS_3D) begin : g_z_on
         assign ntz = z_w[NT_LSB +: NT_W];
      end else begin : g_z_off
         assign ntz = '0;
      end
   endgenerate

   always_comb begin
      ntx    = {{(NT_W-1){1'b0}}, x_w[NT_LSB]};
      nty    = y_w[NT_LSB +: NT_W];
      bw     = (nty > CAP_V) ? CAP_V : nty;
      cw     = (ntz > CAP_V) ? CAP_V : ntz;
      mask_b = (CALC_W'(1) << bw) - CALC_W'(1);
      mask_c = (CALC_W'(1) << cw) - CALC_W'(1);
      a_v    = {{(CALC_W-1){1'b0}}, x_w[22] & x_w[NT_LSB]};
      b_v    = {{(CALC_W-5){1'b0}}, y_w[23:19]} & mask_b;
      c_v    = {{(CALC_W-8){1'b0}}, z_w[23:16]} & mask_c;
      comp   = (((c_v << nty) | b_v) << ntx) | a_v;
      tile_off = x_w[NT_LSB] ? comp[TILE_W-1:0] : {1'b0, comp[TILE_W-2:0]};
      shift_sum = {1'b0, ntx} + {1'b0, nty} + {1'b0, ntz};
   end
endmodule

// File: rtl/tbm_pitch.sv
module tbm_pitch
   import tbm_pkg::*;
(
   input  logic [WORD_W-1:0] x_w,
   input  logic [WORD_W-1:0] z_w,
   output logic [7:0]        byte_off,
   output logic [NT_W-1:0]   el_log2
);
   always_comb begin
      el_log2  = x_w[NT_LSB +: NT_W];
      byte_off = z_w[7:0] << el_log2;
   end
endmodule

// File: rtl/tile_bf_merge.sv
module tile_bf_merge
   import tbm_pkg::*;
#(
   parameter bit IS_3D    = 1'b1,
   parameter int TILE_CAP = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] x_word,
   input  logic [WORD_W-1:0] y_word,
   input  logic [WORD_W-1:0] z_word,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_field,
   output logic              out_oob
);
   generate
      if (TILE_CAP < 1 || TILE_CAP > 7) begin : g_bad_cap
         $error("tile_bf_merge: TILE_CAP must lie in 1..7");
      end
   endgenerate

   logic [INTILE_W-1:0] intile;
   logic [SUM_W-1:0]    shift_sum;
   logic [TILE_W-1:0]   tile_off;
   logic [7:0]          pl_byte;
   logic [NT_W-1:0]     pl_el;
   logic                is_pl, nxt_oob, z_oob;
   logic [WORD_W-1:0]   bl_field, pl_field, nxt_field;

   tbm_swizzle u_swz (
      .x_w    (x_word),
      .y_w    (y_word),
      .intile (intile)
   );

   tbm_tile_compose #(.IS_3D(IS_3D), .TILE_CAP(TILE_CAP)) u_tile (
      .x_w       (x_word),
      .y_w       (y_word),
      .z_w       (z_word),
      .shift_sum (shift_sum),
      .tile_off  (tile_off)
   );

   tbm_pitch u_pitch (
      .x_w      (x_word),
      .z_w      (z_word),
      .byte_off (pl_byte),
      .el_log2  (pl_el)
   );

   generate
      if (IS_3D) begin : g_zoob_on
         assign z_oob = z_word[OOB_BIT];
      end else begin : g_zoob_off
         assign z_oob = 1'b0;
      end
   endgenerate

   always_comb begin
      is_pl   = x_word[PL_BIT] | y_word[PL_BIT];
      nxt_oob = x_word[OOB_BIT] | y_word[OOB_BIT] | z_oob;

      bl_field = '0;
      bl_field[INTILE_W-1:0]              = intile;
      bl_field[SUM_LSB +: SUM_W]          = shift_sum;
      bl_field[TILE_LSB +: TILE_W]        = tile_off;

      pl_field = '0;
      pl_field[7:0]                       = pl_byte;
      pl_field[SUM_LSB +: NT_W]           = pl_el;
      pl_field[PLFLAG_BIT]                = 1'b1;

      nxt_field = is_pl ? pl_field : bl_field;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_field <= '0;
         out_oob   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_field <= nxt_field;
            out_oob   <= nxt_oob;
         end
      end
   end
endmodule

// File: rtl/tbm_merge_chk.sv
module tbm_merge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] x_word,
   input logic [31:0] y_word,
   input logic [31:0] z_word,
   input logic        out_valid,
   input logic [31:0] out_field,
   input logic        out_oob
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
   AST_HOLD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_field) && $stable(out_oob)); // R9
   AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_field[10:9] == 2'b00); // R7
   AST_PL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (x_word[30] || y_word[30]) |=> out_field[11]); // R1
   AST_BL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !x_word[30] && !y_word[30]
      |=> !out_field[11] && out_field[31:27] == 5'd0); // R1
   AST_OOB_XY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (x_word[31] || y_word[31]) |=> out_oob); // R8
   AST_OOB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !x_word[31] && !y_word[31] && !z_word[31] |=> !out_oob); // R8
endmodule

bind tile_bf_merge tbm_merge_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .x_word    (x_word),
   .y_word    (y_word),
   .z_word    (z_word),
   .out_valid (out_valid),
   .out_field (out_field),
   .out_oob   (out_oob)
);

// File: tb/tile_bf_merge_test.sv
module tile_bf_merge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] x_word = '0, y_word = '0, z_word = '0;
   logic        v3, v2, o3, o2;
   logic [31:0] f3, f2;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   tile_bf_merge #(.IS_3D(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .x_word(x_word), .y_word(y_word), .z_word(z_word),
      .out_valid(v3), .out_field(f3), .out_oob(o3));

   tile_bf_merge #(.IS_3D(1'b0)) uut_2d (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .x_word(x_word), .y_word(y_word), .z_word(z_word),
      .out_valid(v2), .out_field(f2), .out_oob(o2));

   function automatic logic [32:0] model(input logic [31:0] x, y, z, input bit three_d);
      logic [31:0] f;
      logic        oob;
      int tx, ty, tz, a, b, c, t, el;
      f   = '0;
      oob = x[31] | y[31] | (z[31] & three_d);
      if (x[30] | y[30]) begin
         el = int'(x[29:27]);
         f[7:0]   = 8'((int'(z[7:0]) * (2 ** el)) % 256);
         f[14:12] = x[29:27];
         f[11]    = 1'b1;
      end else begin
         f[3:0] = x[19:16]; f[4] = y[16]; f[5] = y[17];
         f[6] = x[20]; f[7] = y[18]; f[8] = x[21];
         tx = int'(x[27]);
         ty = int'(y[29:27]);
         tz = three_d ? int'(z[29:27]) : 0;
         f[15:12] = 4'(tx + ty + tz);
         a = tx * int'(x[22]);
         b = int'(y[23:19]) % (2 ** ((ty < 5) ? ty : 5));
         c = int'(z[23:16]) % (2 ** ((tz < 5) ? tz : 5));
         t = (c * (2 ** ty) + b) * (2 ** tx) + a;
         t = t % ((tx == 1) ? 2048 : 1024);
         f[26:16] = 11'(t);
      end
      return {oob, f};
   endfunction

   task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one word set, sample after the capturing edge
   task automatic run(input string req, input logic [31:0] x, y, z);
      @(negedge clk);
      x_word = x; y_word = y; z_word = z; in_valid = 1'b1;
      @(negedge clk);
      check({req, " 3d"}, {o3, f3}, model(x, y, z, 1'b1));
      check({req, " R5 2d"}, {o2, f2}, model(x, y, z, 1'b0));
      check("R9 valid", {31'd0, v3, v2}, {31'd0, 1'b1, 1'b1});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] x, y, z, hold3;
      logic [7:0]  zb [5];
      repeat (3) @(negedge clk);
      check("R10 reset", {o3, f3}, 33'd0);
      check("R10 reset valid", {31'd0, v3, v2}, 33'd0);
      rst_n = 1'b1;

      // R2 R3 R4 R5: full sweep of tile log2 counts
      for (int tx = 0; tx < 2; tx++)
         for (int ty = 0; ty < 8; ty++)
            for (int tz = 0; tz < 8; tz++)
               for (int k = 0; k < 2; k++) begin
                  x = $urandom; y = $urandom; z = $urandom;
                  x[30] = 1'b0; y[30] = 1'b0;
                  x[27] = 1'(tx); y[29:27] = 3'(ty); z[29:27] = 3'(tz);
                  if (k == 1) begin x[23:16] = 8'hFF; y[23:16] = 8'hFF; z[23:16] = 8'hFF; end
                  run("R2 R3 R4 R7", x, y, z);
               end

      // R6 R1: pitch-linear over every element size and byte edges
      zb[0] = 8'h00; zb[1] = 8'h01; zb[2] = 8'h80; zb[3] = 8'hFF; zb[4] = 8'h5A;
      for (int e = 0; e < 8; e++)
         for (int j = 0; j < 5; j++) begin
            x = $urandom; y = $urandom; z = $urandom;
            x[29:27] = 3'(e); z[7:0] = zb[j];
            x[30] = (j % 2 == 0); y[30] = (j % 2 == 1) | (j == 4);
            run("R1 R6 R7", x, y, z);
         end

      // R8: every combination of the top bits, both layouts
      for (int m = 0; m < 16; m++) begin
         x = $urandom; y = $urandom; z = $urandom;
         x[31] = m[0]; y[31] = m[1]; z[31] = m[2];
         x[30] = m[3]; y[30] = 1'b0;
         run("R8 R1", x, y, z);
      end

      // R9: outputs hold while in_valid is low
      @(negedge clk);
      hold3 = f3;
      in_valid = 1'b0;
      x_word = ~x_word; y_word = ~y_word; z_word = ~z_word;
      @(negedge clk);
      check("R9 hold", {v3, f3}, {1'b0, hold3});
      @(negedge clk);
      check("R9 hold2", {v3, f3}, {1'b0, hold3});

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule